// File: doc/BRIEF.md
# Link Clock Rate Estimator

This block measures how fast two incoming high-speed link clocks are running by counting their edges over a fixed interval of a local reference clock. Software picks the reference frequency from a short list of codes. The block turns the interval length into a count of reference cycles, and the edge count of each link clock becomes a range code in steps of 5 MHz. Each channel's code can be read back through a small register port.

The counts cross from each link clock domain into the reference domain through a request/acknowledge snapshot. A channel whose clock has stopped reports code 0. The readable range registers do not follow the estimates continuously. They take new values only when software makes a throw-away read of address 0x00. Software can also write its own value into either range register. Any such write turns automatic estimation off until the next reset.

The first register access after reset raises a sticky error flag. The flag stands in for the link error status that such an access can disturb.

Top module: `clkrate_est_top`

## Requirements
- R1: After reset both range registers read 0, the reference select reads 0, the error flag (bit 0 of address 0x00) is 0 and estimation is enabled.
- R2: For reference select codes 0..4 (12, 19.2, 26, 27, 38.4 MHz), the measuring interval is floor(MHz×10 × WIN_NS / 10000) reference cycles. The estimate is floor(edges/5), where edges is the count of link clock edges in that interval, within ±1 edge.
- R3: An edge count of 5×2^CODE_W or more gives the all-ones code.
- R4: A link clock that has stopped yields code 0 for its channel.
- R5: A range register changes only on a read of address 0x00 while estimation is enabled, or on a software write to it. Reads of other addresses and idle cycles leave it unchanged.
- R6: Channel A (address 0x02, clock lclk_a) and channel B (address 0x03, clock lclk_b) are measured independently.
- R7: A write to address 0x02 or 0x03 stores wdata[CODE_W-1:0] in that range register and disables estimation for both channels. Later reads of 0x00 leave both registers unchanged, and only reset enables estimation again.
- R8: Reference select codes 5..7 are reserved. While one is selected, the estimates stay frozen at their last values. Estimation resumes when a valid code is restored.
- R9: The first read or write after reset sets the error flag (bit 0 of address 0x00). Writing 1 to that bit clears it. Later accesses do not set it again.
- R10: Address 0x01 holds the reference select in its low 3 bits and is read/write. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; register port and estimator logic |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| lclk_a | input | 1 | Link clock measured by channel A |
| lclk_b | input | 1 | Link clock measured by channel B |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of 0x00 refreshes the ranges |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |

## Verification
The bench builds the block with CODE_W = 4 and every other parameter at its default. This puts the saturation point at 80 edges per interval, which a sub-nanosecond link clock reaches even in the shortest 12-cycle interval. The bench sweeps all five valid reference codes against four link periods per channel. It pairs the periods differently on each channel, and expects each code as a ±1-edge band computed from the clock periods. The remaining tests cover stopped clocks, reserved codes, software override and recovery through reset.

// File: rtl/clkrate_est_pkg.sv
package clkrate_est_pkg;

   localparam int unsigned ADR_CTRL  = 0;
   localparam int unsigned ADR_REFSEL = 1;
   localparam int unsigned ADR_RANGE0 = 2;

   localparam int unsigned REFSEL_MAX = 4;

   // reference frequency in units of 100 kHz for each select code
   function automatic int unsigned ref_tenths_mhz(input logic [2:0] sel);
      case (sel)
         3'd0:    return 120;
         3'd1:    return 192;
         3'd2:    return 260;
         3'd3:    return 270;
         3'd4:    return 384;
         default: return 0;
      endcase
   endfunction

   function automatic int unsigned win_cycles(input logic [2:0] sel, input int unsigned win_ns);
      return ref_tenths_mhz(sel) * win_ns / 10000;
   endfunction

   function automatic logic sel_valid(input logic [2:0] sel);
      return sel <= 3'(REFSEL_MAX);
   endfunction

endpackage

// File: rtl/clkrate_link_snap.sv
module clkrate_link_snap #(
   parameter int unsigned CNT_W = 13
) (
   input  logic             lclk,
   input  logic             rst_n,
   input  logic             req_tgl,
   output logic             ack_tgl,
   output logic [CNT_W-1:0] hold
);
   logic [1:0]       rst_pipe;
   logic             lrst_n;
   logic [1:0]       req_sync;
   logic [CNT_W-1:0] edge_cnt;

   always_ff @(posedge lclk or negedge rst_n) begin
      if (!rst_n) rst_pipe <= '0;
      else        rst_pipe <= {rst_pipe[0], 1'b1};
   end
   assign lrst_n = rst_pipe[1];

   always_ff @(posedge lclk or negedge lrst_n) begin
      if (!lrst_n) begin
         edge_cnt <= '0;
         req_sync <= '0;
         ack_tgl  <= 1'b0;
         hold     <= '0;
      end else begin
         edge_cnt <= edge_cnt + 1'b1;
         req_sync <= {req_sync[0], req_tgl};
         if (req_sync[1] != ack_tgl) begin
            hold    <= edge_cnt;
            ack_tgl <= req_sync[1];
         end
      end
   end
endmodule

// File: rtl/clkrate_chan_est.sv
module clkrate_chan_est #(
   parameter int unsigned CNT_W  = 13,
   parameter int unsigned CODE_W = 8,
   parameter int unsigned STEP   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ack_tgl,
   input  logic [CNT_W-1:0]  hold,
   output logic              req_tgl,
   output logic [CODE_W-1:0] code
);
   localparam logic [CNT_W-1:0] SAT_LIM = CNT_W'(STEP * (2 ** CODE_W));

   logic [1:0]       ack_sync;
   logic             waiting;
   logic             have_prev;
   logic [CNT_W-1:0] prev;
   logic [CNT_W-1:0] diff;
   logic [CNT_W-1:0] quo;
   logic             arrived;
   logic             quo_unused;

   assign arrived    = waiting && (ack_sync[1] == req_tgl);
   assign diff       = hold - prev;
   assign quo        = diff / CNT_W'(STEP);
   assign quo_unused = ^quo[CNT_W-1:CODE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_sync  <= '0;
         req_tgl   <= 1'b0;
         waiting   <= 1'b0;
         have_prev <= 1'b0;
         prev      <= '0;
         code      <= '0;
      end else begin
         ack_sync <= {ack_sync[0], ack_tgl};
         if (arrived) begin
            waiting   <= 1'b0;
            prev      <= hold;
            have_prev <= 1'b1;
            if (have_prev) begin
               if (diff >= SAT_LIM) code <= '1;
               else                 code <= quo[CODE_W-1:0];
            end
         end
         if (tick) begin
            if (waiting && !arrived) begin
               code      <= '0;
               have_prev <= 1'b0;
            end else begin
               req_tgl <= ~req_tgl;
               waiting <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/clkrate_window.sv
module clkrate_window
   import clkrate_est_pkg::*;
#(
   parameter int unsigned WIN_NS = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [2:0] refsel,
   output logic       tick
);
   localparam int unsigned WIN_MAX = win_cycles(3'(REFSEL_MAX), WIN_NS);
   localparam int unsigned WIN_W   = $clog2(WIN_MAX + 1);

   logic [WIN_W-1:0] cnt;
   logic [WIN_W-1:0] len_m1;

   assign len_m1 = WIN_W'(win_cycles(refsel, WIN_NS) - 1);
   assign tick   = en && (cnt >= len_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en)        cnt <= cnt;
      else if (tick)       cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/clkrate_regs.sv
module clkrate_regs
   import clkrate_est_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned CODE_W  = 8,
   parameter int unsigned NCH     = 2,
   parameter logic [2:0]  SEL_RST = 3'd0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            addr,
   input  logic                         wr,
   input  logic                         rd,
   input  logic [DATA_W-1:0]            wdata,
   input  logic [NCH-1:0][CODE_W-1:0]   est_code,
   output logic [DATA_W-1:0]            rdata,
   output logic [NCH-1:0][CODE_W-1:0]   range_q,
   output logic [2:0]                   refsel,
   output logic                         est_en,
   output logic                         err_flag
);
   logic           seen;
   logic           dummy_rd;
   logic [NCH-1:0] rng_wr;
   logic           wd_unused;

   assign dummy_rd  = rd && (addr == ADDR_W'(ADR_CTRL));
   assign wd_unused = ^wdata;

   for (genvar g = 0; g < NCH; g++) begin : g_wsel
      assign rng_wr[g] = wr && (addr == ADDR_W'(ADR_RANGE0 + g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         refsel   <= SEL_RST;
         est_en   <= 1'b1;
         err_flag <= 1'b0;
         seen     <= 1'b0;
         range_q  <= '0;
      end else begin
         if (wr && (addr == ADDR_W'(ADR_CTRL)) && wdata[0]) err_flag <= 1'b0;
         if ((rd || wr) && !seen) begin
            err_flag <= 1'b1;
            seen     <= 1'b1;
         end
         if (wr && (addr == ADDR_W'(ADR_REFSEL))) refsel <= wdata[2:0];
         if (dummy_rd && est_en) range_q <= est_code;
         for (int i = 0; i < NCH; i++) begin
            if (rng_wr[i]) range_q[i] <= wdata[CODE_W-1:0];
         end
         if (|rng_wr) est_en <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADR_CTRL))   rdata = DATA_W'(err_flag);
      if (addr == ADDR_W'(ADR_REFSEL)) rdata = DATA_W'(refsel);
      for (int i = 0; i < NCH; i++) begin
         if (addr == ADDR_W'(ADR_RANGE0 + i)) rdata = DATA_W'(range_q[i]);
      end
   end
endmodule

// File: rtl/clkrate_est_top.sv
module clkrate_est_top
   import clkrate_est_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned CODE_W  = 8,
   parameter int unsigned STEP    = 5,
   parameter int unsigned WIN_NS  = 1000,
   parameter logic [2:0]  SEL_RST = 3'd0
) (
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic              lclk_a,
   input  logic              lclk_b,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);
   localparam int unsigned NCH   = 2;
   localparam int unsigned CNT_W = $clog2(STEP * (2 ** CODE_W)) + 2;

   if (CODE_W > DATA_W) begin : g_bad_code_w
      $error("CODE_W must not exceed DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("ADDR_W too small for the register map");
   end
   if (STEP < 1) begin : g_bad_step
      $error("STEP must be at least 1");
   end
   if (win_cycles(3'd0, WIN_NS) < 8) begin : g_bad_win
      $error("WIN_NS gives too short an interval for the snapshot handshake");
   end

   logic [NCH-1:0]              lclk_v;
   logic [NCH-1:0]              req_v;
   logic [NCH-1:0]              ack_v;
   logic [NCH-1:0][CNT_W-1:0]   hold_v;
   logic [NCH-1:0][CODE_W-1:0]  est_code;
   logic [NCH-1:0][CODE_W-1:0]  range_q;
   logic [2:0]                  refsel;
   logic                        est_en;
   logic                        err_flag;
   logic                        tick;
   logic [CODE_W-1:0]           rng_a;
   logic [CODE_W-1:0]           rng_b;

   assign lclk_v = {lclk_b, lclk_a};
   assign rng_a  = range_q[0];
   assign rng_b  = range_q[1];

   clkrate_window #(.WIN_NS(WIN_NS)) i_window (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .en     (est_en && sel_valid(refsel)),
      .refsel (refsel),
      .tick   (tick)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      clkrate_link_snap #(.CNT_W(CNT_W)) i_snap (
         .lclk    (lclk_v[g]),
         .rst_n   (rst_n),
         .req_tgl (req_v[g]),
         .ack_tgl (ack_v[g]),
         .hold    (hold_v[g])
      );
      clkrate_chan_est #(.CNT_W(CNT_W), .CODE_W(CODE_W), .STEP(STEP)) i_est (
         .clk     (clk_ref),
         .rst_n   (rst_n),
         .tick    (tick),
         .ack_tgl (ack_v[g]),
         .hold    (hold_v[g]),
         .req_tgl (req_v[g]),
         .code    (est_code[g])
      );
   end

   clkrate_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .NCH(NCH), .SEL_RST(SEL_RST)
   ) i_regs (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .addr     (reg_addr),
      .wr       (reg_wr),
      .rd       (reg_rd),
      .wdata    (reg_wdata),
      .est_code (est_code),
      .rdata    (reg_rdata),
      .range_q  (range_q),
      .refsel   (refsel),
      .est_en   (est_en),
      .err_flag (err_flag)
   );
endmodule

// File: rtl/clkrate_est_chk.sv
module clkrate_est_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [CODE_W-1:0] rng_a,
   input logic [CODE_W-1:0] rng_b,
   input logic              est_en,
   input logic              err_flag
);
   AST_RANGE_ONLY_ON_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      (!(reg_rd && reg_addr == '0) && !reg_wr) |=> ($stable(rng_a) && $stable(rng_b))); // R5

   AST_OFF_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !est_en |=> !est_en); // R7

   AST_RANGE_WRITE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_addr == ADDR_W'(2) || reg_addr == ADDR_W'(3))) |=> !est_en); // R7

   AST_RANGE_WRITE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(2)) |=> (rng_a == $past(reg_wdata[CODE_W-1:0]))); // R7

   AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!est_en && !reg_wr) |=> ($stable(rng_a) && $stable(rng_b))); // R7

   AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(reg_rd || reg_wr)); // R9
endmodule

bind clkrate_est_top clkrate_est_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)
) i_chk (
   .clk       (clk_ref),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_wdata (reg_wdata),
   .rng_a     (rng_a),
   .rng_b     (rng_b),
   .est_en    (est_en),
   .err_flag  (err_flag)
);

// File: tb/test_clkrate_est_top.sv
`timescale 1ps/1ps
module test_clkrate_est_top;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 8;
   localparam int CODE_W = 4;
   localparam int MAXC   = (1 << CODE_W) - 1;
   localparam int REF_PS = 5000;
   localparam int PA[4]  = '{600, 1000, 1700, 2900};
   localparam int PB[4]  = '{750, 1300, 2300, 4100};

   logic              clk_ref = 1'b0;
   logic              rst_n   = 1'b0;
   logic              lclk_a  = 1'b0;
   logic              lclk_b  = 1'b0;
   logic [ADDR_W-1:0] reg_addr  = '0;
   logic              reg_wr    = 1'b0;
   logic              reg_rd    = 1'b0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;

   int pa = 0;
   int pb = 0;
   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   clkrate_est_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) i_clkrate_est_top (
      .clk_ref(clk_ref), .rst_n(rst_n), .lclk_a(lclk_a), .lclk_b(lclk_b),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   always #(REF_PS/2) clk_ref = ~clk_ref;

   initial forever begin
      if (pa == 0) begin lclk_a = 1'b0; #1000; end
      else begin #(pa/2); lclk_a = ~lclk_a; end
   end
   initial forever begin
      if (pb == 0) begin lclk_b = 1'b0; #1000; end
      else begin #(pb/2); lclk_b = ~lclk_b; end
   end

   function automatic int win(input int rs);
      int t;
      case (rs)
         0: t = 120;
         1: t = 192;
         2: t = 260;
         3: t = 270;
         default: t = 384;
      endcase
      return t * 1000 / 10000;
   endfunction

   task automatic band(input int n, input int p, output int lo, output int hi);
      int lo_e, hi_e;
      if (p == 0) begin lo = 0; hi = 0; return; end
      lo_e = n * REF_PS / p - 1;
      if (lo_e < 0) lo_e = 0;
      hi_e = (n * REF_PS + p - 1) / p + 1;
      lo = lo_e / 5;
      hi = hi_e / 5;
      if (lo > MAXC) lo = MAXC;
      if (hi > MAXC) hi = MAXC;
   endtask

   task automatic chk(input string tag, input int act, input int lo, input int hi);
      compared++;
      if (act < lo || act > hi) begin
         mismatched++;
         $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk_ref);
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk_ref);
      reg_addr = ADDR_W'(a);
      reg_rd = 1'b1;
      #1000;
      d = int'(reg_rdata);
      @(negedge clk_ref);
      reg_rd = 1'b0;
   endtask

   task automatic wr(input int a, input int v);
      @(negedge clk_ref);
      reg_addr = ADDR_W'(a);
      reg_wdata = DATA_W'(v);
      reg_wr = 1'b1;
      @(negedge clk_ref);
      reg_wr = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk_ref);
      rst_n = 1'b0;
      wait_cyc(3);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk_ref);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      int d, lo, hi, sa, sb, n;
      do_reset();
      wait_cyc(2);
      // R1 / R9: reset state, first access sees flag still clear
      rd(0, d); chk("R9 first read flag", d, 0, 0);
      rd(0, d); chk("R9 flag set by first access", d, 1, 1);
      rd(2, d); chk("R1 range A after reset", d, 0, 0);
      rd(3, d); chk("R1 range B after reset", d, 0, 0);
      rd(1, d); chk("R1 refsel after reset", d, 0, 0);
      wr(0, 1);
      rd(0, d); chk("R9 flag cleared by W1C", d, 0, 0);
      rd(0, d); chk("R9 flag not set again", d, 0, 0);
      rd(7, d); chk("R10 unmapped reads zero", d, 0, 0);
      wr(1, 8'hFB);
      rd(1, d); chk("R10 refsel low bits", d, 3, 3);
      wr(1, 0);

      // R5: running clocks, no dummy read -> ranges keep old values
      pa = 1000; pb = 1300;
      wait_cyc(200);
      rd(5, d);
      rd(2, d); chk("R5 A unchanged without trigger", d, 0, 0);
      rd(3, d); chk("R5 B unchanged without trigger", d, 0, 0);
      rd(0, d);
      band(win(0), pa, lo, hi);
      rd(2, d); chk("R5 A refreshed by dummy read", d, lo, hi);

      // R2 / R3 / R6 sweep
      for (int rs = 0; rs < 5; rs++) begin
         wr(1, rs);
         n = win(rs);
         for (int i = 0; i < 4; i++) begin
            pa = PA[i];
            pb = PB[(i + rs) % 4];
            wait_cyc(200);
            rd(0, d);
            band(n, pa, lo, hi);
            rd(2, d);
            if (lo == MAXC) chk("R3 channel A saturated", d, lo, hi);
            else            chk("R2 channel A code", d, lo, hi);
            band(n, pb, lo, hi);
            rd(3, d); chk("R6 channel B code", d, lo, hi);
         end
      end

      // R4: stopped clock
      wr(1, 2);
      pa = 1700; pb = 0;
      wait_cyc(200);
      rd(0, d);
      rd(3, d); chk("R4 stopped clock B", d, 0, 0);
      band(win(2), pa, lo, hi);
      rd(2, d); chk("R6 A unaffected by B stop", d, lo, hi);

      // R8: reserved code freezes estimates
      wr(1, 4);
      pa = 600; pb = 1000;
      wait_cyc(200);
      wr(1, 5);
      pa = 4100;
      wait_cyc(300);
      rd(0, d);
      rd(2, d); chk("R8 frozen under reserved code", d, MAXC, MAXC);
      wr(1, 4);
      wait_cyc(250);
      rd(0, d);
      band(win(4), pa, lo, hi);
      rd(2, d); chk("R8 resumes on valid code", d, lo, hi);

      // R7: software override
      rd(3, sb);
      wr(2, 8'h37);
      rd(2, d); chk("R7 written value A", d, 7, 7);
      rd(3, d); chk("R7 B untouched by A write", d, sb, sb);
      pa = 1000; pb = 2300;
      wait_cyc(200);
      rd(0, d);
      rd(2, d); chk("R7 A held after disable", d, 7, 7);
      rd(3, d); chk("R7 B held after disable", d, sb, sb);
      wr(3, 12);
      rd(0, d);
      rd(3, d); chk("R7 written value B", d, 12, 12);
      rd(2, sa); chk("R7 A still held", sa, 7, 7);

      // R7 / R1: reset re-enables
      do_reset();
      wait_cyc(1);
      rd(2, d); chk("R1 range A cleared by reset", d, 0, 0);
      pa = 1700;
      wait_cyc(200);
      rd(0, d);
      band(win(0), pa, lo, hi);
      rd(2, d); chk("R7 estimation back after reset", d, lo, hi);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule